// File: doc/BRIEF.md
# Paired Counter, Capture and PWM Timer

This block holds four 8-bit counters, numbered 0 to 3, behind a small byte-wide register interface. Each counter steps on a one-cycle tick strobe. Its own 2-bit field picks that strobe from four tick inputs, which come from an external divider. Counting goes up or down, set per counter. Counting up, a counter wraps to zero after it reaches its stored value. Counting down, it reloads the stored value after it reaches zero. Every wrap or reload gives a one-cycle interrupt pulse and a matching event pulse for that counter.

Counters 0 and 1 can be joined into one 16-bit counter, and so can counters 2 and 3. In a joined pair, the low counter's wrap steps the high counter, and only the pair's full wrap raises a pulse, on the high counter's index. A capture register can snapshot any one counter on a rising edge, a falling edge or either edge of an external input. Each pair can also drive a pulse-width output. In that mode the pair runs freely upward with a period of 2^N ticks, where N is 8, 10, 12 or 16. The output is high while the masked pair count is below the masked stored pair value.

Top module: `pairTimerUnit`

## Requirements
- R1: After reset every count, stored value, configuration byte and the capture register read 0, and pwmOut, irqOut and evtOut are all low.
- R2: Configuration bytes at addresses 4 (tick selects, 2 bits per counter, counter 0 in bits 1:0), 5 (bits 3:0 count-down per counter; bit 4 joins counters 0/1; bit 5 joins counters 2/3), 6 (bits 1:0 capture counter, bits 3:2 capture edge, bits 5:4 and 7:6 output sizes of pair 0 and pair 1) and 7 (bits 3:0 counter enables; bits 4 and 5 output enables of pair 0 and pair 1) read back as written. A write to address i (0 to 3) sets the stored value of counter i and loads its count with that value when the counter effectively counts down, or with 0 otherwise. Reads of 0 to 3 return the live counts, and a read of 8 returns the capture register.
- R3: Counting up, each selected tick adds 1, and a count equal to the stored value goes to 0 instead. That wrap pulses irqOut[i] and evtOut[i] high for exactly the one cycle after the stepping edge.
- R4: Counting down, each selected tick subtracts 1, and a count of 0 reloads the stored value instead, with the same one-cycle pulse.
- R5: A counter steps only in a cycle where tickIn[select] is high and its enable bit is set. Ticks on unselected inputs, and any ticks while it is disabled, leave it unchanged.
- R6: In a joined pair, the high counter steps only on the low counter's wrap step, and the low counter's direction bit governs both halves. The high counter's own select, enable and direction bits have no effect. Only the pair's full wrap pulses, and it does so on the high index; the low index never pulses.
- R7: Capture edge codes are 0 off, 1 rising, 2 falling and 3 both. On a selected edge of capIn, the capture register takes the value that the selected counter had in that cycle, and the value can be read in the next cycle.
- R8: With a pair's output enabled, the pair counts up through all values modulo 2^N, ignoring its direction bits and stored values. Size code 0 gives N = 8, 1 gives 10, 2 gives 12 and 3 gives 16. pwmOut is high exactly while (count mod 2^N) < (stored pair value mod 2^N), and it stays low while the output is disabled.
- R9: With a pair's output enabled, the wrap from 2^N-1 to 0 pulses the high index of the pair for one cycle, and the low index stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| tickIn | input | 4 | One-cycle tick strobes, selectable per counter |
| capIn | input | 1 | Synchronous capture input |
| pwmOut | output | 2 | Pulse-width outputs of pair 0 and pair 1 |
| irqOut | output | 4 | Per-counter wrap interrupt pulses |
| evtOut | output | 4 | Per-counter wrap event pulses |

## Verification
Register writes, count steps and wrap pulses all take effect at the clock edge that samples them. The bench drives each stimulus on a falling edge and samples on the next falling edge, one full edge later. Reads and pwmOut are combinational from registered state, so they are sampled in that same cycle after a short settling delay. A capture lands one edge after the capIn change, and each check is placed there. The sweeps run every tick select against every tick input, several stored values in both directions, every capture edge code against every source, and pulse-width periods up to 12 bits using a bench-side arithmetic counter model.

// File: rtl/pairTimerPkg.sv
package pairTimerPkg;
  localparam int NumCnt  = 4;
  localparam int CntW    = 8;
  localparam int AddrW   = 4;
  localparam int NumPair = NumCnt / 2;
  localparam int SelW    = $clog2(NumCnt);
  localparam int IdxW    = $clog2(NumCnt);

  localparam logic [AddrW-1:0] AddrSel  = 4'd4;
  localparam logic [AddrW-1:0] AddrCfg1 = 4'd5;
  localparam logic [AddrW-1:0] AddrCfg2 = 4'd6;
  localparam logic [AddrW-1:0] AddrOn   = 4'd7;
  localparam logic [AddrW-1:0] AddrCap  = 4'd8;

  typedef struct packed {
    logic [NumCnt-1:0] wrCount;
    logic [CntW-1:0]   wrData;
  } ctlStrobeT;

  typedef struct packed {
    logic [NumCnt*SelW-1:0] clkSel;
    logic [NumCnt-1:0]      down;
    logic [NumPair-1:0]     cascade;
    logic [IdxW-1:0]        capSel;
    logic [1:0]             capFunc;
    logic [NumPair*2-1:0]   pwmSize;
    logic [NumCnt-1:0]      enable;
    logic [NumPair-1:0]     pwmEn;
  } cfgT;
endpackage

// File: rtl/timerControl.sv
module timerControl
  import pairTimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [AddrW-1:0] regAddr,
  input  logic [CntW-1:0]  regWrData,
  output cfgT              cfg,
  output ctlStrobeT        strobe,
  output logic [CntW-1:0]  selReg,
  output logic [CntW-1:0]  cfg1Reg,
  output logic [CntW-1:0]  cfg2Reg,
  output logic [CntW-1:0]  onReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      cfg1Reg <= '0;
      cfg2Reg <= '0;
      onReg   <= '0;
    end else if (regWrEn) begin
      if (regAddr == AddrSel)  selReg  <= regWrData;
      if (regAddr == AddrCfg1) cfg1Reg <= regWrData;
      if (regAddr == AddrCfg2) cfg2Reg <= regWrData;
      if (regAddr == AddrOn)   onReg   <= regWrData;
    end
  end

  always_comb begin
    cfg.clkSel  = selReg[NumCnt*SelW-1:0];
    cfg.down    = cfg1Reg[NumCnt-1:0];
    cfg.cascade = cfg1Reg[NumCnt +: NumPair];
    cfg.capSel  = cfg2Reg[IdxW-1:0];
    cfg.capFunc = cfg2Reg[2 +: 2];
    cfg.pwmSize = cfg2Reg[4 +: NumPair*2];
    cfg.enable  = onReg[NumCnt-1:0];
    cfg.pwmEn   = onReg[NumCnt +: NumPair];
    strobe.wrData = regWrData;
    for (int i = 0; i < NumCnt; i++)
      strobe.wrCount[i] = regWrEn && (regAddr == AddrW'(i));
  end

  // R2: a write to the on/off byte is visible on the next cycle
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == AddrOn) |=> (onReg == $past(regWrData)));
endmodule

// File: rtl/timerPair.sv
module timerPair #(
  parameter int CntW    = 8,
  parameter int NumTick = 4,
  localparam int SelW   = $clog2(NumTick),
  localparam int PairW  = 2 * CntW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumTick-1:0] tickIn,
  input  logic [SelW-1:0]    selLo,
  input  logic [SelW-1:0]    selHi,
  input  logic               enLo,
  input  logic               enHi,
  input  logic               downLo,
  input  logic               downHi,
  input  logic               cascade,
  input  logic               pwmEn,
  input  logic [1:0]         pwmSize,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic [CntW-1:0]    wrData,
  output logic [CntW-1:0]    cntLo,
  output logic [CntW-1:0]    cntHi,
  output logic [1:0]         tcPulse,
  output logic               pwmOut
);
  logic [CntW-1:0]  limLo, limHi, hiMask;
  logic [PairW-1:0] fullMask;
  logic joined, effDownLo, effDownHi, stepLo, stepHi, termLo, termHi, pairWrap;
  int   resBits;

  function automatic logic [CntW-1:0] nextVal(input logic [CntW-1:0] cur,
                                              input logic [CntW-1:0] lim,
                                              input logic down, input logic term);
    if (down) return term ? lim : cur - 1'b1;
    return term ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    unique case (pwmSize)
      2'd0:    resBits = CntW;
      2'd1:    resBits = CntW + 2;
      2'd2:    resBits = CntW + 4;
      default: resBits = PairW;
    endcase
    for (int b = 0; b < PairW; b++) fullMask[b] = (b < resBits);
    hiMask = fullMask[PairW-1:CntW];
  end

  always_comb begin
    joined    = cascade | pwmEn;
    effDownLo = downLo & ~pwmEn;
    effDownHi = pwmEn ? 1'b0 : (cascade ? downLo : downHi);
    stepLo    = enLo & tickIn[selLo] & ~wrLo;
    if (pwmEn)          termLo = (cntLo == '1);
    else if (effDownLo) termLo = (cntLo == '0);
    else                termLo = (cntLo == limLo);
    if (pwmEn)          termHi = (cntHi == hiMask);
    else if (effDownHi) termHi = (cntHi == '0);
    else                termHi = (cntHi == limHi);
    if (pwmEn)        stepHi = (pwmSize != 2'd0) & stepLo & termLo & ~wrHi;
    else if (cascade) stepHi = stepLo & termLo & ~wrHi;
    else              stepHi = enHi & tickIn[selHi] & ~wrHi;
    if (pwmEn && pwmSize == 2'd0) pairWrap = stepLo & termLo;
    else                          pairWrap = stepHi & termHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo   <= '0;
      cntHi   <= '0;
      limLo   <= '0;
      limHi   <= '0;
      tcPulse <= '0;
    end else begin
      if (wrLo) begin
        limLo <= wrData;
        cntLo <= effDownLo ? wrData : '0;
      end else if (stepLo) begin
        cntLo <= nextVal(cntLo, limLo, effDownLo, termLo);
      end
      if (wrHi) begin
        limHi <= wrData;
        cntHi <= effDownHi ? wrData : '0;
      end else if (stepHi) begin
        cntHi <= nextVal(cntHi, limHi, effDownHi, termHi);
      end
      tcPulse <= {pairWrap, ~joined & stepLo & termLo};
    end
  end

  assign pwmOut = pwmEn & (({cntHi, cntLo} & fullMask) < ({limHi, limLo} & fullMask));

  // R3: up-counting low half wraps to zero after reaching its stored value
  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stepLo && !pwmEn && !effDownLo && cntLo == limLo) |=> (cntLo == '0));
  // R4: down-counting low half reloads its stored value after zero
  assert_down_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepLo && effDownLo && cntLo == '0) |=> (cntLo == $past(limLo)));
  // R5: a disabled low half never moves without a write
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!enLo && !wrLo) |=> $stable(cntLo));
  // R6: joined high half holds unless the low half wraps
  assert_hi_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cascade && !pwmEn && !(stepLo && termLo) && !wrHi) |=> $stable(cntHi));
  // R6 and R9: low index is silent while the pair is joined
  assert_lo_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cascade || pwmEn) |=> !tcPulse[0]);
  // R8: free-running low half rolls over at all ones
  assert_pwm_roll_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEn && stepLo && cntLo == '1) |=> (cntLo == '0));
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import pairTimerPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  cfgT                          cfg,
  input  ctlStrobeT                    strobe,
  input  logic [NumCnt-1:0]            tickIn,
  input  logic                         capIn,
  output logic [NumCnt-1:0][CntW-1:0]  cntVal,
  output logic [CntW-1:0]              capVal,
  output logic [NumPair-1:0]           pwmOut,
  output logic [NumCnt-1:0]            tcPulse
);
  logic capPrev, capHit;

  for (genvar p = 0; p < NumPair; p++) begin : gPair
    timerPair #(.CntW(CntW), .NumTick(NumCnt)) uPair (
      .clk     (clk),
      .rstN    (rstN),
      .tickIn  (tickIn),
      .selLo   (cfg.clkSel[(2*p)*SelW +: SelW]),
      .selHi   (cfg.clkSel[(2*p+1)*SelW +: SelW]),
      .enLo    (cfg.enable[2*p]),
      .enHi    (cfg.enable[2*p+1]),
      .downLo  (cfg.down[2*p]),
      .downHi  (cfg.down[2*p+1]),
      .cascade (cfg.cascade[p]),
      .pwmEn   (cfg.pwmEn[p]),
      .pwmSize (cfg.pwmSize[2*p +: 2]),
      .wrLo    (strobe.wrCount[2*p]),
      .wrHi    (strobe.wrCount[2*p+1]),
      .wrData  (strobe.wrData),
      .cntLo   (cntVal[2*p]),
      .cntHi   (cntVal[2*p+1]),
      .tcPulse (tcPulse[2*p +: 2]),
      .pwmOut  (pwmOut[p])
    );
  end

  always_comb begin
    unique case (cfg.capFunc)
      2'd1:    capHit = capIn & ~capPrev;
      2'd2:    capHit = ~capIn & capPrev;
      2'd3:    capHit = capIn ^ capPrev;
      default: capHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPrev <= 1'b0;
      capVal  <= '0;
    end else begin
      capPrev <= capIn;
      if (capHit) capVal <= cntVal[cfg.capSel];
    end
  end

  // R7: the capture register only changes on a selected edge
  assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !capHit |=> $stable(capVal));
  // R7: with capture off, an input edge never loads the register
  assert_cap_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.capFunc == 2'd0) |=> $stable(capVal));
endmodule

// File: rtl/pairTimerUnit.sv
module pairTimerUnit
  import pairTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [3:0]  tickIn,
  input  logic        capIn,
  output logic [1:0]  pwmOut,
  output logic [3:0]  irqOut,
  output logic [3:0]  evtOut
);
  cfgT                        cfg;
  ctlStrobeT                  strobe;
  logic [CntW-1:0]            selReg, cfg1Reg, cfg2Reg, onReg, capVal;
  logic [NumCnt-1:0][CntW-1:0] cntVal;
  logic [NumCnt-1:0]          tcPulse;

  timerControl uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfg(cfg), .strobe(strobe),
    .selReg(selReg), .cfg1Reg(cfg1Reg), .cfg2Reg(cfg2Reg), .onReg(onReg)
  );

  timerDatapath uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe), .tickIn(tickIn),
    .capIn(capIn), .cntVal(cntVal), .capVal(capVal), .pwmOut(pwmOut),
    .tcPulse(tcPulse)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr < AddrW'(NumCnt)) regRdData = cntVal[regAddr[IdxW-1:0]];
    else if (regAddr == AddrSel)  regRdData = selReg;
    else if (regAddr == AddrCfg1) regRdData = cfg1Reg;
    else if (regAddr == AddrCfg2) regRdData = cfg2Reg;
    else if (regAddr == AddrOn)   regRdData = onReg;
    else if (regAddr == AddrCap)  regRdData = capVal;
  end

  assign irqOut = tcPulse;
  assign evtOut = tcPulse;
endmodule

// File: tb/tb_pairTimerUnit.sv
`timescale 1ns/1ps
module tb_pairTimerUnit;
  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, capIn = 1'b0;
  logic [3:0] regAddr = '0, tickIn = '0;
  logic [7:0] regWrData = '0, regRdData;
  logic [1:0] pwmOut;
  logic [3:0] irqOut, evtOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pairTimerUnit dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regAddr = 4'(a); regWrData = 8'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = 4'(a);
    #0.5;
    v = int'(regRdData);
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    int v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic pulse(input int m);
    @(negedge clk);
    tickIn = 4'(m);
    @(negedge clk);
    tickIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int e, hi, lo, c, cap, v;
    bit irqE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 9; a++) rdChk(a, 0, "R1 reset read");
    chk(pwmOut == 0, "R1 pwmOut", pwmOut, 0);
    chk(irqOut == 0 && evtOut == 0, "R1 pulses", irqOut, 0);

    // R2: configuration readback
    wr(4, 8'hA5); wr(5, 8'h3C); wr(6, 8'h96); wr(7, 8'hC0);
    rdChk(4, 8'hA5, "R2 sel readback");
    rdChk(5, 8'h3C, "R2 cfg1 readback");
    rdChk(6, 8'h96, "R2 cfg2 readback");
    rdChk(7, 8'hC0, "R2 on readback");
    wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0);

    // R3: up counting on counter 0 for several stored values
    wr(7, 8'h01);
    foreach (e2val[k]) begin end
    for (int k = 0; k < 5; k++) begin
      int lim;
      lim = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 9;
      wr(0, lim);
      rdChk(0, 0, "R2 up write loads zero");
      e = 0;
      for (int s = 0; s < 2 * lim + 4; s++) begin
        pulse(1);
        irqE = (e == lim);
        e = irqE ? 0 : e + 1;
        rdChk(0, e, "R3 up count");
        chk(irqOut[0] == irqE, "R3 irq pulse", irqOut[0], irqE);
        chk(evtOut[0] == irqE, "R3 evt pulse", evtOut[0], irqE);
      end
      @(negedge clk);
      chk(irqOut[0] == 0, "R3 pulse one cycle", irqOut[0], 0);
    end

    // R4: down counting on counter 1, tick input 1
    wr(5, 8'h02); wr(4, 8'h04); wr(7, 8'h02);
    for (int k = 0; k < 3; k++) begin
      int lim;
      lim = (k == 0) ? 0 : (k == 1) ? 3 : 7;
      wr(1, lim);
      rdChk(1, lim, "R2 down write loads value");
      e = lim;
      for (int s = 0; s < 2 * lim + 4; s++) begin
        pulse(2);
        irqE = (e == 0);
        e = irqE ? lim : e - 1;
        rdChk(1, e, "R4 down count");
        chk(irqOut[1] == irqE, "R4 irq pulse", irqOut[1], irqE);
      end
    end
    wr(5, 0);

    // R5: every tick select against every tick input, enabled and disabled
    for (int s = 0; s < 4; s++) begin
      wr(4, s << 4); wr(7, 8'h04); wr(2, 200);
      c = 0;
      for (int t = 0; t < 4; t++) begin
        pulse(1 << t);
        if (t == s) c++;
        rdChk(2, c, "R5 selected tick");
      end
      wr(7, 8'h00);
      pulse(8'hF);
      rdChk(2, c, "R5 disabled ignores ticks");
    end

    // R6: join counters 0/1 counting up
    wr(5, 8'h10); wr(4, 8'h04); wr(7, 8'h01);
    wr(0, 2); wr(1, 1);
    pulse(2);
    rdChk(1, 0, "R6 high select ignored");
    rdChk(0, 0, "R6 low unselected");
    lo = 0; hi = 0;
    for (int s = 0; s < 14; s++) begin
      pulse(1);
      irqE = 0;
      if (lo == 2) begin
        lo = 0;
        if (hi == 1) begin hi = 0; irqE = 1; end else hi++;
      end else lo++;
      rdChk(0, lo, "R6 joined low");
      rdChk(1, hi, "R6 joined high");
      chk(irqOut[1] == irqE, "R6 pair wrap pulse", irqOut[1], irqE);
      chk(irqOut[0] == 0, "R6 low silent", irqOut[0], 0);
    end

    // R6: join counters 2/3 counting down, low direction governs
    wr(5, 8'h24); wr(4, 8'h00); wr(7, 8'h04);
    wr(2, 1); wr(3, 2);
    rdChk(3, 2, "R6 high loads with low direction");
    lo = 1; hi = 2;
    for (int s = 0; s < 12; s++) begin
      pulse(1);
      irqE = 0;
      if (lo == 0) begin
        lo = 1;
        if (hi == 0) begin hi = 2; irqE = 1; end else hi--;
      end else lo--;
      rdChk(2, lo, "R6 joined down low");
      rdChk(3, hi, "R6 joined down high");
      chk(irqOut[3] == irqE, "R6 down pair pulse", irqOut[3], irqE);
      chk(irqOut[2] == 0, "R6 down low silent", irqOut[2], 0);
    end

    // R7: every capture edge code against every source counter
    wr(7, 0); wr(5, 8'h0F);
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44);
    cap = 0;
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        wr(6, (f << 2) | s);
        @(negedge clk); capIn = 1'b1;
        @(negedge clk);
        if (f == 1 || f == 3) cap = 8'h11 * (s + 1);
        rdChk(8, cap, "R7 capture rising");
        capIn = 1'b0;
        @(negedge clk);
        if (f == 2 || f == 3) cap = 8'h11 * (s + 1);
        rdChk(8, cap, "R7 capture falling");
      end
    end

    // R8/R9: pair 0 at 8-bit size
    wr(6, 0); wr(5, 0); wr(4, 0);
    wr(0, 8'h40); wr(1, 0);
    chk(pwmOut[0] == 0, "R8 disabled output low", pwmOut[0], 0);
    wr(7, 8'h11);
    c = 0;
    chk(pwmOut[0] == 1, "R8 start high", pwmOut[0], 1);
    for (int s = 0; s < 300; s++) begin
      pulse(1);
      irqE = (c == 255);
      c = (c + 1) % 256;
      chk(pwmOut[0] == (c < 8'h40), "R8 8-bit duty", pwmOut[0], c < 8'h40);
      chk(irqOut[1] == irqE, "R9 8-bit wrap", irqOut[1], irqE);
      chk(irqOut[0] == 0, "R9 low silent", irqOut[0], 0);
    end

    // R8/R9: pair 0 at 12-bit size, direction bits set and ignored
    wr(6, 8'h20); wr(5, 8'h03); wr(0, 0); wr(1, 8'h0A);
    c = 0;
    for (int s = 0; s < 4200; s++) begin
      pulse(1);
      irqE = (c == 4095);
      c = (c + 1) % 4096;
      chk(pwmOut[0] == (c < 12'hA00), "R8 12-bit duty", pwmOut[0], c < 12'hA00);
      chk(irqOut[1] == irqE, "R9 12-bit wrap", irqOut[1], irqE);
    end
    rd(0, v); chk(v == (c & 255), "R8 12-bit low count", v, c & 255);
    rd(1, v); chk(v == (c >> 8), "R8 12-bit high count", v, c >> 8);

    // R8/R9: pair 1 at 10-bit size
    wr(5, 0); wr(6, 8'h40); wr(2, 8'h80); wr(3, 8'h01); wr(7, 8'h24);
    c = 0;
    for (int s = 0; s < 1100; s++) begin
      pulse(1);
      irqE = (c == 1023);
      c = (c + 1) % 1024;
      chk(pwmOut[1] == (c < 12'h180), "R8 10-bit duty", pwmOut[1], c < 12'h180);
      chk(irqOut[3] == irqE, "R9 10-bit wrap", irqOut[3], irqE);
      chk(irqOut[2] == 0, "R9 10-bit low silent", irqOut[2], 0);
    end
    rd(3, v); chk(v == (c >> 8), "R8 10-bit high count", v, c >> 8);
    wr(7, 0);
    chk(pwmOut == 0, "R8 outputs low when disabled", pwmOut, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int e2val[1];
endmodule